// File: doc/BRIEF.md
# PSRAM Deep-Sleep Sequencer

This block is the power-state manager that takes an asynchronous pseudo-static RAM into its deep power-down state and brings it back out. A system power controller raises `sleep_req` or `wake_req`. The sequencer sits between the memory access controller and the memory's select strobes. In normal operation it passes the controller's chip-select and byte-lane strobes straight through. When a sleep is accepted, it withdraws the access grant and forces every select strobe inactive. After a settle interval it pulls the active-low power-down pin (`mem_pd_n`) low.

On wake, the power-down pin is released at once. The grant stays low until a recovery interval of at least 200 µs has passed, counted in clock cycles. The device does not keep its contents while powered down, so every entry sets a sticky `contents_lost` flag, and the host must acknowledge it explicitly. A wake request that arrives during the settle interval cancels the entry, and the power-down pin is never pulled low. Out of reset the block starts in the recovery phase, so the first access also waits out the full interval.

Top module: `psram_sleep_seq`

## Requirements
- R1: While `rst_n` is low, `mem_pd_n` is 1, `grant` is 0, `contents_lost` is 0 and `mem_cs_n`, `mem_ub_n`, `mem_lb_n` are all 1. After `rst_n` rises, a two-stage synchronizer delays the internal release. `grant` first rises exactly RCV_CYCLES+2 clock edges after the edge at which `rst_n` was seen high.
- R2: While `grant` is 1, `mem_cs_n`, `mem_ub_n` and `mem_lb_n` equal `ctl_cs_n`, `ctl_ub_n` and `ctl_lb_n` in the same cycle, and `mem_pd_n` is 1.
- R3: A sleep request is taken only when `grant` is 1 and `ctl_idle` is 1 at the same clock edge. With `ctl_idle` at 0, `sleep_req` has no effect and `grant` stays 1.
- R4: After an accepted sleep request, `grant` is 0 from the next cycle. `mem_pd_n` stays 1 for SETTLE_CYCLES cycles and then goes to 0. It stays 0 until a wake request is taken.
- R5: Whenever `grant` is 0, including during reset, `mem_cs_n`, `mem_ub_n` and `mem_lb_n` are all 1 whatever the `ctl_*` strobes are.
- R6: A `wake_req` during the settle interval returns the block to the granted state at the next edge, and `mem_pd_n` never goes low.
- R7: A `wake_req` while powered down sets `mem_pd_n` to 1 at the next edge. `grant` rises exactly RCV_CYCLES edges after that, where RCV_CYCLES = ceil(RECOVERY_NS / CLK_PERIOD_NS).
- R8: `contents_lost` goes to 1 on the edge where `mem_pd_n` falls and holds until a cycle with `lost_ack` at 1. On the entry edge, setting wins over `lost_ack`.
- R9: `wake_req` has no effect while granted or recovering. `sleep_req` has no effect while settling, powered down or recovering, and is not remembered for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter deep power-down |
| wake_req | input | 1 | Request to leave deep power-down |
| ctl_idle | input | 1 | Access controller has no access in flight |
| ctl_cs_n | input | 1 | Chip select from the access controller, active low |
| ctl_ub_n | input | 1 | Upper byte-lane enable from the access controller, active low |
| ctl_lb_n | input | 1 | Lower byte-lane enable from the access controller, active low |
| lost_ack | input | 1 | Host acknowledge that clears `contents_lost` |
| mem_cs_n | output | 1 | Chip select to the memory, active low |
| mem_ub_n | output | 1 | Upper byte-lane enable to the memory, active low |
| mem_lb_n | output | 1 | Lower byte-lane enable to the memory, active low |
| mem_pd_n | output | 1 | Deep power-down pin of the memory, low = powered down |
| grant | output | 1 | Access controller may start accesses |
| contents_lost | output | 1 | Sticky flag: memory data must be treated as invalid |

## Verification
The assertions assume `rst_n` is the only source of state loss. They also assume that the clock period parameter matches the real clock, because the recovery window check counts cycles rather than time. The assertions do not constrain `sleep_req`, `wake_req` or `ctl_idle`, so the stimulus may assert any of them in any state. The bench uses this freedom: it holds requests in states where they must be ignored, and it raises an acknowledge on the very edge where the lost flag is set. All inputs change one time unit after a rising edge, so every request is seen as a clean level at the next edge.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_DESEL   = 2'd1,
    PS_SLEEP   = 2'd2,
    PS_RECOVER = 2'd3
  } pwr_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/psram_cycle_timer.sv
module psram_cycle_timer #(
  parameter int LOAD_VAL     = 3,
  parameter int WIDTH        = 2,
  parameter bit RESET_LOADED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = WIDTH'(LOAD_VAL);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - WIDTH'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RESET_LOADED ? WIDTH'(LOAD_VAL) : '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  AST_TMR_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R7

endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
  import psram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       ctl_idle,
  input  logic       settle_zero,
  input  logic       rcv_zero,
  output pwr_state_e state_q,
  output logic       settle_load,
  output logic       rcv_load,
  output logic       sleep_entry
);

  pwr_state_e state_d;

  assign settle_load = (state_q == PS_ACTIVE) && sleep_req && ctl_idle;
  assign rcv_load    = (state_q == PS_SLEEP) && wake_req;
  assign sleep_entry = (state_q == PS_DESEL) && !wake_req && settle_zero;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_ACTIVE:  if (settle_load) state_d = PS_DESEL;
      PS_DESEL: begin
        if (wake_req)         state_d = PS_ACTIVE;
        else if (settle_zero) state_d = PS_SLEEP;
      end
      PS_SLEEP:   if (rcv_load) state_d = PS_RECOVER;
      PS_RECOVER: if (rcv_zero) state_d = PS_ACTIVE;
      default:    state_d = PS_RECOVER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RECOVER;
    end else begin
      state_q <= state_d;
    end
  end

  AST_ENTRY_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DESEL && $past(state_q) == PS_ACTIVE) |-> $past(ctl_idle && sleep_req)); // R3

  AST_CANCEL_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DESEL && wake_req) |=> (state_q == PS_ACTIVE)); // R6

  AST_SLEEP_VIA_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP && $past(state_q) != PS_SLEEP) |-> $past(state_q) == PS_DESEL); // R4

  AST_RECOVER_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RECOVER && $past(state_q) != PS_RECOVER) |-> $past(state_q) == PS_SLEEP); // R7

endmodule

// File: rtl/psram_lost_flag.sv
module psram_lost_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic flag
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set) begin
      flag_d = 1'b1;
    end else if (ack) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack) |=> flag_q); // R8

  AST_LOST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q); // R8

endmodule

// File: rtl/psram_sleep_seq.sv
module psram_sleep_seq
  import psram_pwr_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int RECOVERY_NS   = 200000,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic ctl_idle,
  input  logic ctl_cs_n,
  input  logic ctl_ub_n,
  input  logic ctl_lb_n,
  input  logic lost_ack,
  output logic mem_cs_n,
  output logic mem_ub_n,
  output logic mem_lb_n,
  output logic mem_pd_n,
  output logic grant,
  output logic contents_lost
);

  localparam int RCV_CYCLES = ceil_div(RECOVERY_NS, CLK_PERIOD_NS);
  localparam int RCV_W      = cnt_width(RCV_CYCLES);
  localparam int SET_W      = cnt_width(SETTLE_CYCLES);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_s1_q;
  logic rst_s2_q;
  logic rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign rst_n_i = rst_s2_q;

  pwr_state_e state_q;
  logic       settle_load;
  logic       rcv_load;
  logic       sleep_entry;
  logic       settle_zero;
  logic       rcv_zero;

  psram_pwr_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .sleep_req  (sleep_req),
    .wake_req   (wake_req),
    .ctl_idle   (ctl_idle),
    .settle_zero(settle_zero),
    .rcv_zero   (rcv_zero),
    .state_q    (state_q),
    .settle_load(settle_load),
    .rcv_load   (rcv_load),
    .sleep_entry(sleep_entry)
  );

  psram_cycle_timer #(
    .LOAD_VAL    (SETTLE_CYCLES - 1),
    .WIDTH       (SET_W),
    .RESET_LOADED(1'b0)
  ) i_settle_tmr (
    .clk  (clk),
    .rst_n(rst_n_i),
    .load (settle_load),
    .zero (settle_zero)
  );

  psram_cycle_timer #(
    .LOAD_VAL    (RCV_CYCLES - 1),
    .WIDTH       (RCV_W),
    .RESET_LOADED(1'b1)
  ) i_rcv_tmr (
    .clk  (clk),
    .rst_n(rst_n_i),
    .load (rcv_load),
    .zero (rcv_zero)
  );

  psram_lost_flag i_lost (
    .clk  (clk),
    .rst_n(rst_n_i),
    .set  (sleep_entry),
    .ack  (lost_ack),
    .flag (contents_lost)
  );

  always_comb begin
    grant    = (state_q == PS_ACTIVE);
    mem_pd_n = (state_q != PS_SLEEP);
    mem_cs_n = 1'b1;
    mem_ub_n = 1'b1;
    mem_lb_n = 1'b1;
    if (grant) begin
      mem_cs_n = ctl_cs_n;
      mem_ub_n = ctl_ub_n;
      mem_lb_n = ctl_lb_n;
    end
  end

  // window checker: cycles since power-down pin released, without a grant
  logic        chk_armed_q;
  logic [31:0] chk_cnt_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chk_armed_q <= 1'b1;
      chk_cnt_q   <= '0;
    end else begin
      if (!mem_pd_n) begin
        chk_armed_q <= 1'b1;
        chk_cnt_q   <= '0;
      end else if (grant) begin
        chk_armed_q <= 1'b0;
      end else if (chk_cnt_q < 32'(RCV_CYCLES)) begin
        chk_cnt_q <= chk_cnt_q + 32'd1;
      end
    end
  end

  AST_RECOVERY_WAIT: assert property (@(posedge clk) disable iff (!rst_n_i)
    ($rose(grant) && chk_armed_q) |-> (chk_cnt_q >= 32'(RCV_CYCLES))); // R7

  AST_PD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n_i)
    !mem_pd_n |-> (mem_cs_n && mem_ub_n && mem_lb_n && !grant)); // R5

  AST_DESEL_BEFORE_PD: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(mem_pd_n) |-> ($past(mem_cs_n) && $past(mem_ub_n) && $past(mem_lb_n) && !$past(grant))); // R4

  AST_LOST_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(mem_pd_n) |-> contents_lost); // R8

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n_i)
    grant |-> (mem_cs_n == ctl_cs_n && mem_ub_n == ctl_ub_n && mem_lb_n == ctl_lb_n && mem_pd_n)); // R2

endmodule

// File: tb/test_psram_sleep_seq.sv
module test_psram_sleep_seq;

  localparam int CLK_PER   = 10;
  localparam int DUT_CLKNS = 1500;
  localparam int DUT_RCVNS = 200000;
  localparam int DUT_SET   = 2;
  localparam int EXP_RCV   = (DUT_RCVNS + DUT_CLKNS - 1) / DUT_CLKNS; // 134

  // {wake_req, sleep_req, cs_n, ub_n, lb_n}; idle held low
  localparam logic [4:0] VEC [8] = '{
    5'b00_000, 5'b01_001, 5'b10_010, 5'b11_011,
    5'b00_100, 5'b01_101, 5'b10_110, 5'b11_111
  };

  logic clk = 1'b0;
  logic rst_n, sleep_req, wake_req, ctl_idle, ctl_cs_n, ctl_ub_n, ctl_lb_n, lost_ack;
  logic mem_cs_n, mem_ub_n, mem_lb_n, mem_pd_n, grant, contents_lost;

  int n_cmp = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  psram_sleep_seq #(
    .CLK_PERIOD_NS(DUT_CLKNS),
    .RECOVERY_NS  (DUT_RCVNS),
    .SETTLE_CYCLES(DUT_SET)
  ) i_psram_sleep_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .ctl_idle(ctl_idle), .ctl_cs_n(ctl_cs_n), .ctl_ub_n(ctl_ub_n), .ctl_lb_n(ctl_lb_n),
    .lost_ack(lost_ack), .mem_cs_n(mem_cs_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_pd_n(mem_pd_n), .grant(grant), .contents_lost(contents_lost)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_grant(output int n);
    n = 0;
    while (grant !== 1'b1 && n < 1000) begin
      step();
      n++;
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; ctl_idle = 1'b0;
    ctl_cs_n = 1'b0; ctl_ub_n = 1'b0; ctl_lb_n = 1'b0; lost_ack = 1'b0;
    repeat (3) step();
    // R1 / R5: reset state with strobes driven active
    chk("R1 pd_n in reset", 32'(mem_pd_n), 1);
    chk("R1 grant in reset", 32'(grant), 0);
    chk("R1 lost in reset", 32'(contents_lost), 0);
    chk("R5 strobes in reset", {29'd0, mem_cs_n, mem_ub_n, mem_lb_n}, 32'h7);
    rst_n = 1'b1;
    wait_grant(n);
    chk("R1 reset recovery length", 32'(n), 32'(EXP_RCV + 2));

    // R2 / R3 / R9: table walk while granted, idle low
    foreach (VEC[i]) begin
      {wake_req, sleep_req, ctl_cs_n, ctl_ub_n, ctl_lb_n} = VEC[i];
      #1;
      chk("R2 pass-through", {29'd0, mem_cs_n, mem_ub_n, mem_lb_n}, {29'd0, VEC[i][2:0]});
      step();
      chk("R3 R9 grant kept", 32'(grant), 1);
      chk("R2 pd_n high", 32'(mem_pd_n), 1);
    end
    {wake_req, sleep_req, ctl_cs_n, ctl_ub_n, ctl_lb_n} = 5'b00_000;

    // R4 / R5 / R8: sleep entry
    ctl_idle = 1'b1; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R4 grant drops", 32'(grant), 0);
    chk("R5 strobes forced", {29'd0, mem_cs_n, mem_ub_n, mem_lb_n}, 32'h7);
    chk("R4 pd_n settle 1", 32'(mem_pd_n), 1);
    step();
    chk("R4 pd_n settle 2", 32'(mem_pd_n), 1);
    step();
    chk("R4 pd_n low", 32'(mem_pd_n), 0);
    chk("R8 lost set", 32'(contents_lost), 1);
    sleep_req = 1'b1;
    repeat (3) step();
    sleep_req = 1'b0;
    chk("R4 R9 pd_n stays low", 32'(mem_pd_n), 0);

    // R7: wake and recovery length
    wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    chk("R7 pd_n released", 32'(mem_pd_n), 1);
    chk("R7 no grant yet", 32'(grant), 0);
    wait_grant(n);
    chk("R7 recovery length", 32'(n), 32'(EXP_RCV));
    chk("R8 lost sticky", 32'(contents_lost), 1);
    lost_ack = 1'b1;
    step();
    lost_ack = 1'b0;
    chk("R8 lost cleared", 32'(contents_lost), 0);

    // R6: cancel during settle
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0; wake_req = 1'b1;
    chk("R6 pd_n in settle", 32'(mem_pd_n), 1);
    step();
    wake_req = 1'b0;
    chk("R6 grant back", 32'(grant), 1);
    chk("R6 pd_n never low", 32'(mem_pd_n), 1);
    repeat (3) step();
    chk("R6 pd_n still high", 32'(mem_pd_n), 1);
    chk("R6 lost untouched", 32'(contents_lost), 0);

    // R8: set wins over a held acknowledge
    lost_ack = 1'b1; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    step();
    step();
    chk("R8 set beats ack", 32'(contents_lost), 1);
    step();
    lost_ack = 1'b0;
    chk("R8 ack clears in sleep", 32'(contents_lost), 0);

    // R9: sleep request held during recovery is dropped
    wake_req = 1'b1;
    step();
    wake_req = 1'b0; sleep_req = 1'b1;
    repeat (5) step();
    sleep_req = 1'b0;
    wait_grant(n);
    chk("R9 recovery with sleep_req", 32'(n + 5), 32'(EXP_RCV));
    repeat (4) step();
    chk("R9 stale sleep_req ignored", 32'(grant), 1);
    chk("R9 pd_n high", 32'(mem_pd_n), 1);

    done = 1'b1;
    finish_run();
  end

endmodule